// File: doc/BRIEF.md
# Field-Selected Word Transfer Unit

This block moves part of a word between a register and a memory word in a sign-magnitude machine. A word is a sign bit plus five 6-bit bytes. A field specification names a contiguous span of positions. Position 0 is the sign and positions 1 to 5 are the bytes, with byte 1 the most significant. A load pulls the named span out of the memory word and right-aligns it into a register value. A negated load does the same and then flips the sign. A store writes the low-order bytes of the register into the named span of the memory word and keeps every other byte as it was. A store can therefore patch, for example, only the address part of an instruction word.

The data path is combinational. One registered stage holds the result, a valid flag and an invalid-request flag. A two-state controller drives the valid flag:
- `ST_IDLE` moves to `ST_DONE` when `in_valid` is high.
- `ST_DONE` stays in `ST_DONE` when another request arrives.
- `ST_DONE` returns to `ST_IDLE` when no request arrives.

`out_valid` is high exactly in `ST_DONE`. Address generation, indexing and the memory array are outside this block.

Top module: `fld_xfer_unit`

## Requirements
- R1: Word layout and field encoding.
  - Word layout: the sign is bit 30, and byte k (k = 1..5) occupies bits [6*(5-k)+5 : 6*(5-k)], so byte 1 is [29:24] and byte 5 is [5:0].
  - `fspec` equals 8*first + last, with first in bits [5:3] and last in bits [2:0].
  - `op` encoding: 2'b00 is load, 2'b01 is negated load, 2'b10 is store and 2'b11 is reserved.
  - A load with spec (0:5) returns the memory word unchanged.
- R2: A load places memory bytes max(first,1)..last in the lowest result bytes, keeping their order, and clears every other result byte to zero.
- R3: On a plain load, the result sign equals the memory sign when first = 0 and is positive (0) otherwise.
- R4: A negated load gives the same magnitude as a load and the inverted sign. This holds for +0 and for -0.
- R5: A store writes the rightmost (last - max(first,1) + 1) register bytes into memory bytes max(first,1)..last and leaves all other memory bytes unchanged.
- R6: On a store, the result sign equals the register sign when first = 0 and otherwise keeps the memory sign.
- R7: A request is invalid when first > last, when last > 5, or when `op` = 2'b11. An invalid request sets `out_bad` and leaves `out_word` unchanged.
- R8: Timing of the output stage.
  - `out_valid`, `out_bad` and `out_word` update on the clock edge after the edge that samples `in_valid`.
  - With no request, `out_valid` is low and `out_word` holds its value.
- R9: Under reset, `out_valid`, `out_bad` and `out_word` are all zero.
- R10: Spec (0:0) selects only the sign.
  - A load gives a zero magnitude carrying the memory sign.
  - A store changes only the sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | Operation select: load, negated load, store, reserved |
| fspec | input | 6 | Field specification, 8*first + last |
| mem_word | input | 31 | Memory word (sign plus five bytes) |
| reg_word | input | 31 | Register word (sign plus five bytes) |
| out_valid | output | 1 | Result valid, one cycle after a request |
| out_bad | output | 1 | The last request had an invalid spec or op |
| out_word | output | 31 | Load result, or the merged word for a store |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing;
- that the word is held while idle or after a rejected request;
- that an invalid spec is flagged;
- the sign rules for loads, negated loads and partial stores.

Only the bench sweep can show that the magnitudes are right. That covers byte alignment, zero fill of the unselected result bytes, and the untouched bytes of a store. The sweep runs every spec and every op against signed, zero and negative-zero words, and compares each result with a model computed from shifts and masks.

// File: rtl/fld_xfer_pkg.sv
package fld_xfer_pkg;

    localparam int DEF_BYTE_W = 6;
    localparam int DEF_NBYTES = 5;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_LOADN = 2'b01,
        OP_STORE = 2'b10,
        OP_RSVD  = 2'b11
    } xfer_op_e;

    // Decoded field: byte span lo..hi, sign inclusion, alignment distance
    typedef struct packed {
        logic       bad;
        logic [2:0] lo;
        logic [2:0] hi;
        logic       incl_sign;
        logic [2:0] shamt;
    } fld_dec_t;

endpackage

// File: rtl/fld_spec_decode.sv
module fld_spec_decode
    import fld_xfer_pkg::*;
#(
    parameter int NBYTES = DEF_NBYTES
) (
    input  logic [5:0] fspec,
    input  logic [1:0] op,
    output fld_dec_t   dec
);
    logic [2:0] first_pos;
    logic [2:0] last_pos;

    assign first_pos = fspec[5:3];
    assign last_pos  = fspec[2:0];

    always_comb begin
        dec.bad       = (first_pos > last_pos) || (last_pos > 3'(NBYTES)) ||
                        (op == OP_RSVD);
        dec.incl_sign = (first_pos == 3'd0);
        dec.lo        = (first_pos == 3'd0) ? 3'd1 : first_pos;
        dec.hi        = last_pos;
        dec.shamt     = 3'(NBYTES) - last_pos;
    end
endmodule

// File: rtl/fld_load_extract.sv
module fld_load_extract
    import fld_xfer_pkg::*;
#(
    parameter int BYTE_W = DEF_BYTE_W,
    parameter int NBYTES = DEF_NBYTES,
    localparam int WORD_W = 1 + NBYTES * BYTE_W
) (
    input  logic [WORD_W-1:0] mem_word,
    input  fld_dec_t          dec,
    input  logic              negate,
    output logic [WORD_W-1:0] result
);
    always_comb begin
        result = '0;
        for (int k = 1; k <= NBYTES; k++) begin
            for (int j = 1; j <= NBYTES; j++) begin
                if ((j + int'(dec.shamt) == k) && (j >= int'(dec.lo))) begin
                    result[(NBYTES-k)*BYTE_W +: BYTE_W] =
                        mem_word[(NBYTES-j)*BYTE_W +: BYTE_W];
                end
            end
        end
        result[WORD_W-1] = (dec.incl_sign ? mem_word[WORD_W-1] : 1'b0) ^ negate;
    end
endmodule

// File: rtl/fld_store_merge.sv
module fld_store_merge
    import fld_xfer_pkg::*;
#(
    parameter int BYTE_W = DEF_BYTE_W,
    parameter int NBYTES = DEF_NBYTES,
    localparam int WORD_W = 1 + NBYTES * BYTE_W
) (
    input  logic [WORD_W-1:0] mem_word,
    input  logic [WORD_W-1:0] reg_word,
    input  fld_dec_t          dec,
    output logic [WORD_W-1:0] result
);
    always_comb begin
        result = mem_word;
        for (int k = 1; k <= NBYTES; k++) begin
            if ((k >= int'(dec.lo)) && (k <= int'(dec.hi))) begin
                for (int j = 1; j <= NBYTES; j++) begin
                    if (j == k + int'(dec.shamt)) begin
                        result[(NBYTES-k)*BYTE_W +: BYTE_W] =
                            reg_word[(NBYTES-j)*BYTE_W +: BYTE_W];
                    end
                end
            end
        end
        if (dec.incl_sign) begin
            result[WORD_W-1] = reg_word[WORD_W-1];
        end
    end
endmodule

// File: rtl/fld_xfer_unit.sv
module fld_xfer_unit
    import fld_xfer_pkg::*;
#(
    parameter int BYTE_W = DEF_BYTE_W,
    parameter int NBYTES = DEF_NBYTES,
    localparam int WORD_W = 1 + NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op,
    input  logic [5:0]        fspec,
    input  logic [WORD_W-1:0] mem_word,
    input  logic [WORD_W-1:0] reg_word,
    output logic              out_valid,
    output logic              out_bad,
    output logic [WORD_W-1:0] out_word
);
    typedef enum logic {ST_IDLE, ST_DONE} stage_e;

    stage_e            state_q;
    stage_e            state_d;
    fld_dec_t          dec;
    logic [WORD_W-1:0] load_res;
    logic [WORD_W-1:0] store_res;

    fld_spec_decode #(.NBYTES(NBYTES)) u_dec (
        .fspec (fspec),
        .op    (op),
        .dec   (dec)
    );

    fld_load_extract #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_load (
        .mem_word (mem_word),
        .dec      (dec),
        .negate   (op == OP_LOADN),
        .result   (load_res)
    );

    fld_store_merge #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_store (
        .mem_word (mem_word),
        .reg_word (reg_word),
        .dec      (dec),
        .result   (store_res)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = in_valid ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign out_valid = (state_q == ST_DONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_bad  <= 1'b0;
            out_word <= '0;
        end else if (in_valid) begin
            out_bad <= dec.bad;
            if (!dec.bad) begin
                out_word <= (op == OP_STORE) ? store_res : load_res;
            end
        end
    end
endmodule

// File: rtl/fld_xfer_chk.sv
module fld_xfer_chk #(
    parameter int BYTE_W = 6,
    parameter int NBYTES = 5,
    localparam int WORD_W = 1 + NBYTES * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        op,
    input logic [5:0]        fspec,
    input logic [WORD_W-1:0] mem_word,
    input logic [WORD_W-1:0] out_word,
    input logic              out_valid,
    input logic              out_bad
);
    logic good_req;
    logic first_nz;

    assign good_req = (fspec[5:3] <= fspec[2:0]) && (fspec[2:0] <= 3'(NBYTES)) &&
                      (op != 2'b11);
    assign first_nz = (fspec[5:3] != 3'd0);

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid) else $error("valid timing");                       // R8
    AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_word)) else $error("idle hold");    // R8
    AST_BAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !good_req |=> out_bad && $stable(out_word)) else $error("bad"); // R7
    AST_LOAD_SIGN_POS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && good_req && op == 2'b00 && first_nz |=> !out_word[WORD_W-1])
        else $error("load sign");                                                   // R3
    AST_LOADN_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && good_req && op == 2'b01 && !first_nz |=>
        out_word[WORD_W-1] != $past(mem_word[WORD_W-1])) else $error("neg sign");   // R4
    AST_STORE_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && good_req && op == 2'b10 && first_nz |=>
        out_word[WORD_W-1] == $past(mem_word[WORD_W-1])) else $error("store sign"); // R6
endmodule

bind fld_xfer_unit fld_xfer_chk #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .fspec     (fspec),
    .mem_word  (mem_word),
    .out_word  (out_word),
    .out_valid (out_valid),
    .out_bad   (out_bad)
);

// File: tb/tb_fld_xfer_unit.sv
`timescale 1ns/1ps
module tb_fld_xfer_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [5:0]  fspec = 6'd0;
    logic [30:0] mem_word = '0;
    logic [30:0] reg_word = '0;
    logic        out_valid;
    logic        out_bad;
    logic [30:0] out_word;

    int n_chk = 0;
    int n_err = 0;
    logic [30:0] held = '0;
    logic [30:0] pats [4];

    always #4 clk = ~clk;

    fld_xfer_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .fspec(fspec),
        .mem_word(mem_word), .reg_word(reg_word),
        .out_valid(out_valid), .out_bad(out_bad), .out_word(out_word)
    );

    task automatic chk(input string tag, input logic [30:0] act, input logic [30:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [30:0] model(input int o, input int f,
                                          input logic [30:0] m, input logic [30:0] r);
        int first = f / 8;
        int last = f % 8;
        int n = (first == 0) ? last : last - first + 1;
        int sh = 6 * (5 - last);
        logic [63:0] fm = (64'd1 << (6 * n)) - 64'd1;
        logic [63:0] mm = {34'd0, m[29:0]};
        logic [63:0] rm = {34'd0, r[29:0]};
        logic [63:0] mask;
        logic [63:0] mag;
        logic s;
        if (o == 2) begin
            mask = fm << sh;
            mag  = (mm & ~mask) | ((rm << sh) & mask);
            s    = (first == 0) ? r[30] : m[30];
        end else begin
            mag = (mm >> sh) & fm;
            s   = (first == 0) ? m[30] : 1'b0;
            if (o == 1) s = ~s;
        end
        return {s, mag[29:0]};
    endfunction

    function automatic bit is_bad(input int o, input int f);
        return (o == 3) || (f / 8 > f % 8) || (f % 8 > 5);
    endfunction

    task automatic run(input int o, input int f, input logic [30:0] m, input logic [30:0] r);
        logic [30:0] exp;
        string tag;
        bit bad = is_bad(o, f);
        @(negedge clk);
        op = 2'(o); fspec = 6'(f); mem_word = m; reg_word = r; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 out_valid", {30'd0, out_valid}, 31'd1);
        chk(bad ? "R7 out_bad" : "R7 out_bad clear", {30'd0, out_bad}, {30'd0, bad});
        if (bad) begin
            chk("R7 word held", out_word, held);
        end else begin
            exp = model(o, f, m, r);
            if (f == 0)      tag = "R10 sign-only field";
            else if (o == 2) tag = "R5 store merge";
            else if (o == 1) tag = "R4 negated load";
            else             tag = "R2 load align";
            chk(tag, out_word, exp);
            if (o == 2)      tag = "R6 store sign";
            else if (o == 1) tag = "R4 negated sign";
            else             tag = "R3 load sign";
            chk(tag, {30'd0, out_word[30]}, {30'd0, exp[30]});
            held = exp;
        end
    endtask

    initial begin
        #1_600_000;
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        pats[0] = {1'b0, 30'h2B3C5D6E};
        pats[1] = {1'b1, 30'h1234ABCD};
        pats[2] = {1'b1, 30'h00000000};
        pats[3] = {1'b0, 30'h3FFFFFFF};
        repeat (3) @(negedge clk);
        chk("R9 reset out_valid", {30'd0, out_valid}, 31'd0);
        chk("R9 reset out_bad", {30'd0, out_bad}, 31'd0);
        chk("R9 reset out_word", out_word, 31'd0);
        rst_n = 1'b1;

        // R1: full-word load (0:5) returns the memory word exactly
        run(0, 5, pats[1], pats[0]);
        chk("R1 full word load", out_word, pats[1]);

        for (int p = 0; p < 4; p++) begin
            for (int o = 0; o < 4; o++) begin
                for (int f = 0; f < 64; f++) begin
                    run(o, f, pats[p], pats[(p + 1) % 4]);
                end
                @(negedge clk);
                chk("R8 idle out_valid low", {30'd0, out_valid}, 31'd0);
                chk("R8 idle word held", out_word, held);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule